// File: doc/BRIEF.md
# Audio Codec Register Initializer

This block is a write-only two-wire (I2C) master that sets up a stereo audio codec once the chip leaves reset. A start pulse makes it walk a fixed table of 16-bit control words. Each word holds a 7-bit codec register address in its upper bits and 9 bits of register data in its lower bits. It sends each word as one bus write. A write is three bytes: the codec's device write address, then the register address shifted up one place with data bit 8 in the least significant bit, then data bits 7 to 0. The codec must acknowledge every byte.

The pins are open-drain. The block only ever pulls SCL or SDA low, and it reads the SDA level back through a synchronizer to sample the acknowledge bits. When the table has been sent, the block raises done and accepts single register writes from a neighbouring block through a valid/ready port. A not-acknowledge at any point ends the write with a STOP and raises a sticky error flag. During bring-up it also stops the table.

Top module: `codec_cfg_master`

## Requirements
- R1: After a start pulse the block sends nine writes. Their byte triples, in this order, are 34 00 00, 34 02 00, 34 0C 06, 34 08 10, 34 0E 00, 34 10 A0, 34 12 01, 34 04 01, 34 06 01 (hex). The power-control word (third) precedes the interface-activation and volume words.
- R2: Each write is exactly three bytes, sent most significant bit first. Byte 0 is the device write address 0x34. Byte 1 is word[15:8], which is the 7-bit register address shifted left one place with data bit 8 as its LSB. Byte 2 is word[7:0]. The word 0x0CFF (register 0x06, data 0xFF) goes out as 34 0C FF.
- R3: Out of reset both line pull-downs are off and busy, done, error and req_ready are low.
- R4: busy is high from the clock edge that accepts a start until the sequence ends, and the block never pulls a line while busy is low. After the ninth write is acknowledged, done is high, busy is low and req_ready is high.
- R5: While SCL is high, SDA changes only to form a START (falling) or a STOP (rising). Each write is framed by exactly one START and one STOP.
- R6: The acknowledge is sampled while SCL is high on the ninth clock of each byte. A released (high) SDA there is a not-acknowledge. The block then issues a STOP and sets error, sends no further table entries and leaves done low.
- R7: A request is accepted on a clock edge where req_valid and req_ready are both high. The word is then sent as one write as in R2. req_ready is high only when the table has completed and the block is not busy.
- R8: A not-acknowledge during a request write sets error while done stays high.
- R9: A start pulse that arrives while busy has no effect. The sequence in progress completes with exactly nine writes.
- R10: A start pulse when idle, after completion or after an error, clears done and error and sends the table again from its first entry.
- R11: One SCL period lasts 4*CLK_DIV system clocks.
- R12: req_valid has no effect while req_ready is low: no bus activity follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle pulse that launches the bring-up table |
| req_valid_i | input | 1 | Single-write request valid |
| req_word_i | input | 16 | Request word: address in [15:9], data in [8:0] |
| req_ready_o | output | 1 | Request can be accepted this cycle |
| scl_oe_o | output | 1 | Pull SCL low when high |
| sda_oe_o | output | 1 | Pull SDA low when high |
| sda_i | input | 1 | Sampled SDA line level |
| busy_o | output | 1 | A sequence or request write is in progress |
| done_o | output | 1 | Bring-up table completed |
| error_o | output | 1 | A not-acknowledge was seen (sticky until next start) |

## Verification
The hardest situation to reach is a not-acknowledge in the middle of the table, because a well-behaved codec always acknowledges. The bench's slave model takes an index into the received byte stream and withholds the acknowledge at exactly that byte. This makes the second write fail on its register byte. The bench then confirms that a STOP follows, that no later bytes appear and that a fresh start replays the whole table. A second case withholds the acknowledge of a request's final data byte after bring-up, which separates the error flag from the done flag.

// File: rtl/codec_init_pkg.sv
package codec_init_pkg;

  localparam int CFG_WORD_W = 16;
  localparam int BOOT_LEN   = 9;
  localparam int BOOT_IDX_W = $clog2(BOOT_LEN);

  typedef enum logic [1:0] {PH_IDLE, PH_START, PH_BITS, PH_STOP} bus_phase_t;
  typedef enum logic [1:0] {SQ_IDLE, SQ_BOOT_GO, SQ_BOOT_WAIT, SQ_EXT_WAIT} seq_state_t;

  // Join a 7-bit register address and 9-bit data into one control word.
  function automatic logic [CFG_WORD_W-1:0] cfg_word(input logic [6:0] reg_a,
                                                     input logic [8:0] reg_d);
    return {reg_a, reg_d};
  endfunction

  // Byte k of the bus write for a control word.
  function automatic logic [7:0] wire_byte(input logic [7:0] dev_wr,
                                           input logic [CFG_WORD_W-1:0] w,
                                           input logic [1:0] k);
    case (k)
      2'd0:    return dev_wr;
      2'd1:    return w[15:8];
      default: return w[7:0];
    endcase
  endfunction

  // Bring-up table; the device power control word precedes activation.
  function automatic logic [CFG_WORD_W-1:0] boot_word(input int unsigned i);
    case (i)
      0:       return cfg_word(7'h00, 9'h000);
      1:       return cfg_word(7'h01, 9'h000);
      2:       return cfg_word(7'h06, 9'h006);
      3:       return cfg_word(7'h04, 9'h010);
      4:       return cfg_word(7'h07, 9'h000);
      5:       return cfg_word(7'h08, 9'h0A0);
      6:       return cfg_word(7'h09, 9'h001);
      7:       return cfg_word(7'h02, 9'h001);
      default: return cfg_word(7'h03, 9'h001);
    endcase
  endfunction

endpackage

// File: rtl/cfg_sda_sync.sv
module cfg_sda_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  generate
    if (STAGES == 0) begin : g_pass
      assign q_o = d_i;
    end else begin : g_chain
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else if (STAGES == 1) chain <= d_i;
        else chain <= {chain[STAGES-2:0], d_i};
      end
      assign q_o = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/cfg_i2c_engine.sv
module cfg_i2c_engine
  import codec_init_pkg::*;
#(
  parameter int         CLK_DIV = 250,
  parameter logic [7:0] DEV_WR  = 8'h34
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  go_i,
  input  logic [CFG_WORD_W-1:0] word_i,
  input  logic                  sda_i,
  output logic                  scl_oe_o,
  output logic                  sda_oe_o,
  output logic                  busy_o,
  output logic                  fin_o,
  output logic                  nack_o,
  output logic                  ack_smp_o,
  output logic                  ctl_phase_o
);
  localparam int              DIV_W    = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);
  localparam logic [3:0]      ACK_BIT  = 4'd8;
  localparam logic [1:0]      LAST_BYTE = 2'd2;

  bus_phase_t            phase;
  logic [DIV_W-1:0]      div_cnt;
  logic [1:0]            q;
  logic [1:0]            byte_k;
  logic [3:0]            bit_n;
  logic [7:0]            shreg;
  logic [CFG_WORD_W-1:0] word_q;
  logic                  sda_hold;
  logic                  nack_q;
  logic                  fin_q;
  logic                  tick;
  logic                  cur_low;
  logic                  is_ack;

  assign tick    = (phase != PH_IDLE) && (div_cnt == DIV_LAST);
  assign is_ack  = (bit_n == ACK_BIT);
  assign cur_low = is_ack ? 1'b0 : ~shreg[7];

  // Line drive per quarter of a bit: SCL low in quarters 0-1, high in 2-3.
  always_comb begin
    scl_oe_o = 1'b0;
    sda_oe_o = 1'b0;
    case (phase)
      PH_START: begin
        scl_oe_o = (q == 2'd3);
        sda_oe_o = q[1];
      end
      PH_BITS: begin
        scl_oe_o = ~q[1];
        sda_oe_o = (q == 2'd0) ? sda_hold : cur_low;
      end
      PH_STOP: begin
        scl_oe_o = ~q[1];
        sda_oe_o = (q == 2'd0) ? sda_hold : (q != 2'd3);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      div_cnt  <= '0;
      q        <= '0;
      byte_k   <= '0;
      bit_n    <= '0;
      shreg    <= '0;
      word_q   <= '0;
      sda_hold <= 1'b0;
      nack_q   <= 1'b0;
      fin_q    <= 1'b0;
    end else begin
      fin_q <= 1'b0;
      if (phase == PH_IDLE || div_cnt == DIV_LAST) div_cnt <= '0;
      else div_cnt <= div_cnt + 1'b1;

      if (phase == PH_IDLE) begin
        if (go_i) begin
          phase  <= PH_START;
          q      <= '0;
          word_q <= word_i;
          nack_q <= 1'b0;
        end
      end else if (tick) begin
        q <= q + 2'd1;
        case (phase)
          PH_START: if (q == 2'd3) begin
            phase    <= PH_BITS;
            byte_k   <= '0;
            bit_n    <= '0;
            shreg    <= wire_byte(DEV_WR, word_q, 2'd0);
            sda_hold <= 1'b1;
          end
          PH_BITS: begin
            if (q == 2'd2 && is_ack) nack_q <= sda_i;
            if (q == 2'd3) begin
              sda_hold <= cur_low;
              if (is_ack) begin
                if (nack_q || byte_k == LAST_BYTE) begin
                  phase <= PH_STOP;
                end else begin
                  byte_k <= byte_k + 2'd1;
                  bit_n  <= '0;
                  shreg  <= wire_byte(DEV_WR, word_q, byte_k + 2'd1);
                end
              end else begin
                bit_n <= bit_n + 4'd1;
                shreg <= {shreg[6:0], 1'b0};
              end
            end
          end
          PH_STOP: if (q == 2'd3) begin
            phase <= PH_IDLE;
            fin_q <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  assign busy_o      = (phase != PH_IDLE);
  assign fin_o       = fin_q;
  assign nack_o      = nack_q;
  assign ack_smp_o   = tick && (phase == PH_BITS) && (q == 2'd2) && is_ack;
  assign ctl_phase_o = (phase == PH_START) || (phase == PH_STOP);
endmodule

// File: rtl/cfg_seq.sv
module cfg_seq
  import codec_init_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic                  req_valid_i,
  input  logic [CFG_WORD_W-1:0] req_word_i,
  output logic                  req_ready_o,
  input  logic                  eng_fin_i,
  input  logic                  eng_nack_i,
  output logic                  go_o,
  output logic [CFG_WORD_W-1:0] word_o,
  output logic                  busy_o,
  output logic                  done_o,
  output logic                  error_o
);
  localparam logic [BOOT_IDX_W-1:0] LAST_IDX = BOOT_IDX_W'(BOOT_LEN - 1);

  seq_state_t            st;
  logic [BOOT_IDX_W-1:0] idx;
  logic                  done_q;
  logic                  err_q;
  logic                  go_q;
  logic [CFG_WORD_W-1:0] word_q;

  assign req_ready_o = (st == SQ_IDLE) && done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= SQ_IDLE;
      idx    <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      go_q   <= 1'b0;
      word_q <= '0;
    end else begin
      go_q <= 1'b0;
      case (st)
        SQ_IDLE: begin
          if (start_i) begin
            idx    <= '0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
            st     <= SQ_BOOT_GO;
          end else if (req_valid_i && req_ready_o) begin
            go_q   <= 1'b1;
            word_q <= req_word_i;
            st     <= SQ_EXT_WAIT;
          end
        end
        SQ_BOOT_GO: begin
          go_q   <= 1'b1;
          word_q <= boot_word(int'(idx));
          st     <= SQ_BOOT_WAIT;
        end
        SQ_BOOT_WAIT: if (eng_fin_i) begin
          if (eng_nack_i) begin
            err_q <= 1'b1;
            st    <= SQ_IDLE;
          end else if (idx == LAST_IDX) begin
            done_q <= 1'b1;
            st     <= SQ_IDLE;
          end else begin
            idx <= idx + 1'b1;
            st  <= SQ_BOOT_GO;
          end
        end
        SQ_EXT_WAIT: if (eng_fin_i) begin
          err_q <= err_q | eng_nack_i;
          st    <= SQ_IDLE;
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

  assign go_o    = go_q;
  assign word_o  = word_q;
  assign busy_o  = (st != SQ_IDLE);
  assign done_o  = done_q;
  assign error_o = err_q;
endmodule

// File: rtl/codec_cfg_master.sv
module codec_cfg_master
  import codec_init_pkg::*;
#(
  parameter int         CLK_DIV     = 250,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] DEV_WR      = 8'h34
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic                  req_valid_i,
  input  logic [CFG_WORD_W-1:0] req_word_i,
  output logic                  req_ready_o,
  output logic                  scl_oe_o,
  output logic                  sda_oe_o,
  input  logic                  sda_i,
  output logic                  busy_o,
  output logic                  done_o,
  output logic                  error_o
);
  logic                  sda_s_w;
  logic                  eng_go_w;
  logic [CFG_WORD_W-1:0] eng_word_w;
  logic                  eng_busy_w;
  logic                  eng_fin_w;
  logic                  eng_nack_w;
  logic                  ack_smp_w;
  logic                  ctl_phase_w;

  cfg_sda_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(sda_i), .q_o(sda_s_w)
  );

  cfg_i2c_engine #(.CLK_DIV(CLK_DIV), .DEV_WR(DEV_WR)) u_eng (
    .clk(clk), .rst_n(rst_n), .go_i(eng_go_w), .word_i(eng_word_w),
    .sda_i(sda_s_w), .scl_oe_o(scl_oe_o), .sda_oe_o(sda_oe_o),
    .busy_o(eng_busy_w), .fin_o(eng_fin_w), .nack_o(eng_nack_w),
    .ack_smp_o(ack_smp_w), .ctl_phase_o(ctl_phase_w)
  );

  cfg_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .req_valid_i(req_valid_i), .req_word_i(req_word_i), .req_ready_o(req_ready_o),
    .eng_fin_i(eng_fin_w), .eng_nack_i(eng_nack_w),
    .go_o(eng_go_w), .word_o(eng_word_w),
    .busy_o(busy_o), .done_o(done_o), .error_o(error_o)
  );
endmodule

// File: rtl/codec_cfg_master_chk.sv
module codec_cfg_master_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_oe,
  input logic sda_oe,
  input logic busy,
  input logic done,
  input logic error,
  input logic eng_go,
  input logic eng_busy,
  input logic eng_fin,
  input logic eng_nack,
  input logic ack_smp,
  input logic ctl_phase
);
  // R5: SDA holds while SCL stays high outside START/STOP framing.
  p_sda_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_oe && !$past(scl_oe) && !ctl_phase && !$past(ctl_phase))
      |-> (sda_oe == $past(sda_oe)));

  // R4: the lines are only pulled while the sequencer reports busy.
  p_lines_need_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_oe || sda_oe) |-> busy);

  // R6: a not-acknowledged write raises error on the next cycle.
  p_nack_sets_error_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_fin && eng_nack) |=> error);

  // R6: the acknowledge sample never happens with SCL pulled low.
  p_ack_when_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_smp |-> !scl_oe);

  // R9: a new write is launched only when the engine is idle.
  p_go_only_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    eng_go |-> !eng_busy);

  // R1: completion of the table is never flagged together with an error.
  p_done_clean_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> !error);
endmodule

bind codec_cfg_master codec_cfg_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_oe(scl_oe_o), .sda_oe(sda_oe_o),
  .busy(busy_o), .done(done_o), .error(error_o),
  .eng_go(eng_go_w), .eng_busy(eng_busy_w), .eng_fin(eng_fin_w),
  .eng_nack(eng_nack_w), .ack_smp(ack_smp_w), .ctl_phase(ctl_phase_w)
);

// File: tb/codec_cfg_master_test.sv
`timescale 1ns/1ps
module codec_cfg_master_test;
  localparam int DIV = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [15:0] req_word_i = '0;
  logic        req_ready_o, scl_oe_o, sda_oe_o, busy_o, done_o, error_o;
  logic        slave_pull = 1'b0;
  wire         scl_line = ~scl_oe_o;
  wire         sda_line = ~(sda_oe_o | slave_pull);

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  codec_cfg_master #(.CLK_DIV(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .req_valid_i(req_valid_i), .req_word_i(req_word_i), .req_ready_o(req_ready_o),
    .scl_oe_o(scl_oe_o), .sda_oe_o(sda_oe_o), .sda_i(sda_line),
    .busy_o(busy_o), .done_o(done_o), .error_o(error_o)
  );

  always #2 clk = ~clk;

  localparam logic [7:0] BOOT_BYTES [27] = '{
    8'h34, 8'h00, 8'h00,  8'h34, 8'h02, 8'h00,  8'h34, 8'h0C, 8'h06,
    8'h34, 8'h08, 8'h10,  8'h34, 8'h0E, 8'h00,  8'h34, 8'h10, 8'hA0,
    8'h34, 8'h12, 8'h01,  8'h34, 8'h04, 8'h01,  8'h34, 8'h06, 8'h01};

  // Slave model state
  logic [7:0] rx_log [64];
  int  log_n = 0, starts = 0, stops = 0, nack_at = -1;
  int  bitcnt = 0, last_rise = 0, period = 0;
  logic ackph = 1'b0, in_frame = 1'b0, p_scl = 1'b1, p_sda = 1'b1;
  logic [7:0] rx_sh = '0;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (rst_n) begin
      if (p_scl && scl_line && p_sda && !sda_line) begin
        starts = starts + 1; bitcnt = 0; ackph = 1'b0; slave_pull = 1'b0; in_frame = 1'b1;
      end else if (p_scl && scl_line && !p_sda && sda_line) begin
        stops = stops + 1; in_frame = 1'b0; slave_pull = 1'b0;
      end else if (!p_scl && scl_line) begin
        if (in_frame && bitcnt > 0 && bitcnt <= 8 && last_rise > 0) period = cyc - last_rise;
        last_rise = cyc;
        if (bitcnt < 8) begin rx_sh = {rx_sh[6:0], sda_line}; bitcnt = bitcnt + 1; end
      end else if (p_scl && !scl_line && in_frame) begin
        if (ackph) begin
          slave_pull = 1'b0; ackph = 1'b0; bitcnt = 0;
        end else if (bitcnt == 8) begin
          if (log_n < 64) rx_log[log_n] = rx_sh;
          slave_pull = (log_n != nack_at);
          log_n = log_n + 1;
          ackph = 1'b1;
        end
      end
    end
    p_scl = scl_line;
    p_sda = sda_line;
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_log();
    log_n = 0; starts = 0; stops = 0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy_o && n < 30000) begin @(negedge clk); n++; end
    repeat (4) @(negedge clk);
  endtask

  task automatic send_req(input logic [15:0] w);
    @(negedge clk);
    chk(req_ready_o == 1'b1, "R7 ready before request", req_ready_o, 1);
    req_valid_i = 1'b1; req_word_i = w;
    @(negedge clk);
    req_valid_i = 1'b0;
    chk(busy_o == 1'b1 && req_ready_o == 1'b0, "R7 busy/not-ready after accept",
        {busy_o, req_ready_o}, 2);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(!scl_oe_o && !sda_oe_o, "R3 lines released", {scl_oe_o, sda_oe_o}, 0);
    chk(!busy_o && !done_o && !error_o, "R3 status low", {busy_o, done_o, error_o}, 0);
    chk(!req_ready_o, "R3 ready low", req_ready_o, 0);
  endtask

  task automatic t_req_before_boot();
    clear_log();
    @(negedge clk); req_valid_i = 1'b1; req_word_i = 16'h0CFF;
    repeat (200) @(negedge clk);
    chk(starts == 0 && !busy_o, "R12 request ignored while not ready", starts, 0);
    req_valid_i = 1'b0;
  endtask

  task automatic t_boot();
    clear_log(); nack_at = -1;
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    chk(busy_o == 1'b1, "R4 busy after start", busy_o, 1);
    wait_idle();
    chk(log_n == 27, "R1 byte count", log_n, 27);
    for (int i = 0; i < 27; i++)
      chk(rx_log[i] == BOOT_BYTES[i], "R1 R2 boot byte", rx_log[i], BOOT_BYTES[i]);
    chk(starts == 9 && stops == 9, "R5 one START and STOP per write", starts * 100 + stops, 909);
    chk(done_o && !busy_o && req_ready_o, "R4 done/busy/ready after table",
        {done_o, busy_o, req_ready_o}, 5);
    chk(!error_o, "R4 no error", error_o, 0);
    chk(period == 4 * DIV, "R11 SCL period", period, 4 * DIV);
  endtask

  task automatic t_ext();
    clear_log(); nack_at = -1;
    send_req(16'h0CFF);
    wait_idle();
    chk(log_n == 3, "R7 request write length", log_n, 3);
    chk(rx_log[0] == 8'h34 && rx_log[1] == 8'h0C && rx_log[2] == 8'hFF, "R2 request bytes",
        {rx_log[0], rx_log[1], rx_log[2]}, 24'h340CFF);
    chk(done_o && !error_o && req_ready_o, "R7 status after request",
        {done_o, error_o, req_ready_o}, 5);
  endtask

  task automatic t_ext_nack();
    clear_log(); nack_at = 2;
    send_req(16'h0501);
    wait_idle();
    chk(log_n == 3 && stops == 1, "R8 request write stopped", log_n * 10 + stops, 31);
    chk(error_o && done_o, "R8 error with done kept", {error_o, done_o}, 3);
    nack_at = -1;
  endtask

  task automatic t_boot_nack();
    clear_log(); nack_at = 4;
    pulse_start();
    wait_idle();
    repeat (300) @(negedge clk);
    chk(log_n == 5, "R6 no bytes after NACK", log_n, 5);
    chk(stops == 2 && starts == 2, "R6 STOP after NACK", starts * 10 + stops, 22);
    chk(error_o && !done_o && !busy_o, "R6 error, halted", {error_o, done_o, busy_o}, 4);
    chk(!req_ready_o, "R7 no ready after failed table", req_ready_o, 0);
    nack_at = -1;
  endtask

  task automatic t_restart();
    clear_log();
    pulse_start();
    chk(!done_o && !error_o, "R10 flags cleared on restart", {done_o, error_o}, 0);
    wait_idle();
    chk(log_n == 27 && rx_log[0] == 8'h34 && rx_log[2] == 8'h00, "R10 table replayed from first",
        log_n, 27);
    chk(done_o && !error_o, "R10 done after replay", {done_o, error_o}, 2);
  endtask

  task automatic t_start_busy();
    clear_log();
    pulse_start();
    repeat (300) @(negedge clk);
    pulse_start();
    wait_idle();
    chk(starts == 9 && log_n == 27, "R9 start ignored while busy", starts, 9);
    chk(done_o && !busy_o, "R9 sequence finished", {done_o, busy_o}, 2);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_req_before_boot();
    t_boot();
    t_ext();
    t_ext_nack();
    t_boot_nack();
    t_restart();
    t_start_busy();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors = errors + 1;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule